// File: doc/BRIEF.md
# SPI Slave Function-0 Control and Interrupt Register Bank

This block is the register file that sits behind the command decoder of a SPI slave device. The decoder accesses it one byte at a time through an address, a write strobe and write data. A read returns data combinationally on the read-data bus. The bank holds the bus configuration bits: word width, byte order, clock-edge mode and interrupt-pin polarity. It also holds the controls that decide whether a status word goes back to the host after each transfer. Writing the wake bit produces a one-cycle request toward the power logic.

Hardware events from the FIFO and packet logic arrive as one-cycle pulses. Each pulse latches a bit in a 16-bit interrupt status register. A 16-bit enable register masks those bits. The interrupt pin follows the masked result in the programmed polarity. The pin is held inactive while a status word is being returned, unless the host has asked to be interrupted anyway. A 32-bit status word is sampled from the surrounding logic every cycle and can be read byte by byte.

Top module: `spi_fn0_regbank`

## Requirements
- R1: After reset, address 0x00 reads 0x30, address 0x02 reads 0x00, addresses 0x04/0x05 read 0x00, address 0x06 reads 0xE7, address 0x07 reads 0xE0, addresses 0x08–0x0B read 0x00, and wakeReq and irqPin are low.
- R2: A write to address 0x00 takes effect at the next clock edge. Bit 0 drives wordLen32, bit 1 drives bigEndian, bit 4 drives highSpeed and bit 5 drives irqActiveHigh. Bits 2, 3 and 6 read back as 0.
- R3: Writing address 0x00 with bit 7 set raises wakeReq for exactly the one cycle after the write edge. Writing it with bit 7 clear raises no pulse. Bit 7 reads back the value last written.
- R4: At address 0x02, bit 0 drives statusEn and bit 1 drives irqWithStatus, and the other bits read 0. Addresses 0x01 and 0x03 read 0 and ignore writes.
- R5: A one-cycle pulse on evtSet[i] sets interrupt status bit i at the next edge, for i in {0,1,2,5,6,7,13,14,15}. Address 0x04 shows bits 7:0 and address 0x05 shows bits 15:8. All other bit positions stay 0.
- R6: Writing 1 to bit 0 of address 0x04 clears status bit 0. Every other bit of 0x04 and 0x05 is unaffected by writes.
- R7: When a set pulse meets a clear in the same cycle, the bit ends up set. The clear may come from the write-1 clear at 0x04 bit 0 or from evtClear.
- R8: A one-cycle pulse on evtClear[i] clears status bit i at the next edge.
- R9: The 16-bit enable register is read/write. Address 0x06 holds bits 7:0 and address 0x07 holds bits 15:8.
- R10: The interrupt is active when any status bit and its enable bit are both 1. irqPin equals the active state when address 0x00 bit 5 is 1, and equals its inverse when bit 5 is 0.
- R11: While statusActive is high and irqWithStatus is 0, irqPin shows the inactive level. With irqWithStatus at 1, statusActive has no effect on irqPin.
- R12: The status word samples statusIn at every edge. It is read with bits 7:0 at 0x08 through bits 31:24 at 0x0B, and writes to 0x08–0x0B are ignored. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regAddr | input | ADDR_W | Byte address from the command decoder |
| regWrEn | input | 1 | Write strobe for the addressed byte |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data for regAddr (combinational) |
| evtSet | input | 16 | Per-bit set pulses for interrupt status |
| evtClear | input | 16 | Per-bit clear pulses for interrupt status |
| statusIn | input | 32 | Live status word from surrounding logic |
| statusActive | input | 1 | High while a status word is being returned |
| wordLen32 | output | 1 | 1 selects 32-bit words, 0 selects 16-bit words |
| bigEndian | output | 1 | 1 selects big-endian byte order |
| highSpeed | output | 1 | 1 samples and drives on the rising edge; 0 drives on the falling edge |
| irqActiveHigh | output | 1 | Interrupt pin polarity |
| statusEn | output | 1 | Return status after each transfer |
| irqWithStatus | output | 1 | Allow interrupt while status is returned |
| wakeReq | output | 1 | One-cycle wake request |
| irqPin | output | 1 | Interrupt pin in the programmed polarity |

## Verification
The bench builds the bank with its default parameters: a 6-bit address, the 0xE7/0xE0 implemented and enable masks, and the 0x30 configuration reset. The 6-bit address space lets the bench read an address above the status word and confirm that it returns zero. Because the implemented mask matches the enable reset value, an all-ones set pulse exposes every real source and shows that the gap positions stay at zero. The cases that matter most are a set pulse colliding with a clear, and a polarity change while an interrupt is pending.

// File: rtl/spi_fn0_pkg.sv
package spi_fn0_pkg;

  localparam int IRQ_W     = 16;
  localparam int STW_W     = 32;
  localparam int IRQ_BYTES = IRQ_W / 8;
  localparam int STW_BYTES = STW_W / 8;

  localparam int CFG_ADDR = 0;
  localparam int RPT_ADDR = 2;
  localparam int IRQ_ADDR = 4;
  localparam int IEN_ADDR = 6;
  localparam int STW_ADDR = 8;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_BUS,
    SEL_RPT,
    SEL_IRQ,
    SEL_IEN,
    SEL_STW
  } rd_sel_e;

  typedef struct packed {
    logic                 busCfgWr;
    logic                 rptCfgWr;
    logic                 irqW1c;
    logic [IRQ_BYTES-1:0] ienWr;
    rd_sel_e              rdSel;
    logic [1:0]           rdByte;
  } ctrl_strb_t;

endpackage

// File: rtl/spi_fn0_ctrl.sv
module spi_fn0_ctrl
  import spi_fn0_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  output ctrl_strb_t        strb
);

  localparam logic [ADDR_W-1:0] A_CFG = ADDR_W'(CFG_ADDR);
  localparam logic [ADDR_W-1:0] A_RPT = ADDR_W'(RPT_ADDR);
  localparam logic [ADDR_W-1:0] A_IRQ = ADDR_W'(IRQ_ADDR);
  localparam logic [ADDR_W-1:0] A_IEN = ADDR_W'(IEN_ADDR);
  localparam logic [ADDR_W-1:0] A_STW = ADDR_W'(STW_ADDR);

  logic [ADDR_W-1:0] irqOff;
  logic [ADDR_W-1:0] ienOff;
  logic [ADDR_W-1:0] stwOff;

  assign irqOff = regAddr - A_IRQ;
  assign ienOff = regAddr - A_IEN;
  assign stwOff = regAddr - A_STW;

  always_comb begin
    strb       = '0;
    strb.rdSel = SEL_NONE;
    if (regAddr == A_CFG) begin
      strb.rdSel    = SEL_BUS;
      strb.busCfgWr = regWrEn;
    end else if (regAddr == A_RPT) begin
      strb.rdSel    = SEL_RPT;
      strb.rptCfgWr = regWrEn;
    end else if (regAddr >= A_IRQ && regAddr < A_IRQ + ADDR_W'(IRQ_BYTES)) begin
      strb.rdSel  = SEL_IRQ;
      strb.rdByte = 2'(irqOff);
      strb.irqW1c = regWrEn && (regAddr == A_IRQ);
    end else if (regAddr >= A_IEN && regAddr < A_IEN + ADDR_W'(IRQ_BYTES)) begin
      strb.rdSel  = SEL_IEN;
      strb.rdByte = 2'(ienOff);
      for (int b = 0; b < IRQ_BYTES; b++) begin
        strb.ienWr[b] = regWrEn && (2'(ienOff) == 2'(b));
      end
    end else if (regAddr >= A_STW && regAddr < A_STW + ADDR_W'(STW_BYTES)) begin
      strb.rdSel  = SEL_STW;
      strb.rdByte = 2'(stwOff);
    end
  end

  AST_STW_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdSel == SEL_STW) |-> !(strb.busCfgWr || strb.rptCfgWr || strb.irqW1c || (|strb.ienWr))) // R12
    else $error("write strobe raised on status word");

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $countones({strb.busCfgWr, strb.rptCfgWr, strb.irqW1c, strb.ienWr}) <= 1) // R4
    else $error("more than one write strobe");

endmodule

// File: rtl/spi_fn0_data.sv
module spi_fn0_data
  import spi_fn0_pkg::*;
#(
  parameter logic [7:0]       BUS_RESET = 8'h30,
  parameter logic [IRQ_W-1:0] IRQ_IMPL  = 16'hE0E7,
  parameter logic [IRQ_W-1:0] IEN_RESET = 16'hE0E7
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrl_strb_t       strb,
  input  logic [7:0]       wrData,
  input  logic [IRQ_W-1:0] evtSet,
  input  logic [IRQ_W-1:0] evtClear,
  input  logic [STW_W-1:0] statusIn,
  input  logic             statusActive,
  output logic [7:0]       rdData,
  output logic             wordLen32,
  output logic             bigEndian,
  output logic             highSpeed,
  output logic             irqActiveHigh,
  output logic             statusEn,
  output logic             irqWithStatus,
  output logic             wakeReq,
  output logic             irqPin
);

  localparam logic [7:0] BUS_MASK = 8'hB3;
  localparam logic [1:0] RPT_MASK = 2'b11;

  logic [7:0]       busCfg;
  logic [1:0]       rptCfg;
  logic [IRQ_W-1:0] irqStat;
  logic [IRQ_W-1:0] irqEn;
  logic [STW_W-1:0] statReg;
  logic [IRQ_W-1:0] w1cMask;
  logic [IRQ_W-1:0] irqNext;
  logic             irqFire;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busCfg  <= BUS_RESET & BUS_MASK;
      wakeReq <= 1'b0;
    end else begin
      wakeReq <= strb.busCfgWr && wrData[7];
      if (strb.busCfgWr) busCfg <= wrData & BUS_MASK;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rptCfg <= '0;
    else if (strb.rptCfgWr) rptCfg <= wrData[1:0] & RPT_MASK;
  end

  always_comb begin
    w1cMask = '0;
    if (strb.irqW1c) w1cMask[0] = wrData[0];
    irqNext = ((irqStat & ~(evtClear | w1cMask)) | evtSet) & IRQ_IMPL;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqStat <= '0;
    else       irqStat <= irqNext;
  end

  for (genvar b = 0; b < IRQ_BYTES; b++) begin : g_ien
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)              irqEn[8*b +: 8] <= IEN_RESET[8*b +: 8];
      else if (strb.ienWr[b]) irqEn[8*b +: 8] <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) statReg <= '0;
    else       statReg <= statusIn;
  end

  always_comb begin
    rdData = '0;
    case (strb.rdSel)
      SEL_BUS: rdData = busCfg;
      SEL_RPT: rdData = {6'b0, rptCfg};
      SEL_IRQ: rdData = irqStat[{strb.rdByte[0], 3'b000} +: 8];
      SEL_IEN: rdData = irqEn[{strb.rdByte[0], 3'b000} +: 8];
      SEL_STW: rdData = statReg[{strb.rdByte, 3'b000} +: 8];
      default: rdData = '0;
    endcase
  end

  assign wordLen32     = busCfg[0];
  assign bigEndian     = busCfg[1];
  assign highSpeed     = busCfg[4];
  assign irqActiveHigh = busCfg[5];
  assign statusEn      = rptCfg[0];
  assign irqWithStatus = rptCfg[1];

  assign irqFire = (|(irqStat & irqEn)) && (!statusActive || rptCfg[1]);
  assign irqPin  = busCfg[5] ? irqFire : !irqFire;

  AST_WAKE_FROM_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    wakeReq |-> $past(strb.busCfgWr && wrData[7])) // R3
    else $error("wake pulse without wake write");

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    $past(evtSet[0]) |-> irqStat[0]) // R7
    else $error("set lost against clear");

  AST_UNIMPL_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (irqStat & ~IRQ_IMPL) == '0) // R5
    else $error("unimplemented interrupt bit set");

  AST_QUIET_STATUS: assert property (@(posedge clk) disable iff (!rstN)
    (statusActive && !irqWithStatus) |-> (irqPin == !irqActiveHigh)) // R11
    else $error("interrupt shown during status");

  AST_IEN_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !$past(|strb.ienWr) |-> $stable(irqEn)) // R9
    else $error("enable changed without write");

endmodule

// File: rtl/spi_fn0_regbank.sv
module spi_fn0_regbank
  import spi_fn0_pkg::*;
#(
  parameter int               ADDR_W    = 6,
  parameter logic [7:0]       BUS_RESET = 8'h30,
  parameter logic [IRQ_W-1:0] IRQ_IMPL  = 16'hE0E7,
  parameter logic [IRQ_W-1:0] IEN_RESET = 16'hE0E7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [7:0]        regWrData,
  output logic [7:0]        regRdData,
  input  logic [IRQ_W-1:0]  evtSet,
  input  logic [IRQ_W-1:0]  evtClear,
  input  logic [STW_W-1:0]  statusIn,
  input  logic              statusActive,
  output logic              wordLen32,
  output logic              bigEndian,
  output logic              highSpeed,
  output logic              irqActiveHigh,
  output logic              statusEn,
  output logic              irqWithStatus,
  output logic              wakeReq,
  output logic              irqPin
);

  ctrl_strb_t strb;

  spi_fn0_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .regAddr (regAddr),
    .regWrEn (regWrEn),
    .strb    (strb)
  );

  spi_fn0_data #(
    .BUS_RESET (BUS_RESET),
    .IRQ_IMPL  (IRQ_IMPL),
    .IEN_RESET (IEN_RESET)
  ) u_data (
    .clk           (clk),
    .rstN          (rstN),
    .strb          (strb),
    .wrData        (regWrData),
    .evtSet        (evtSet),
    .evtClear      (evtClear),
    .statusIn      (statusIn),
    .statusActive  (statusActive),
    .rdData        (regRdData),
    .wordLen32     (wordLen32),
    .bigEndian     (bigEndian),
    .highSpeed     (highSpeed),
    .irqActiveHigh (irqActiveHigh),
    .statusEn      (statusEn),
    .irqWithStatus (irqWithStatus),
    .wakeReq       (wakeReq),
    .irqPin        (irqPin)
  );

endmodule

// File: tb/spi_fn0_regbank_bench.sv
module spi_fn0_regbank_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [5:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [7:0]  regWrData = '0;
  logic [7:0]  regRdData;
  logic [15:0] evtSet = '0;
  logic [15:0] evtClear = '0;
  logic [31:0] statusIn = '0;
  logic        statusActive = 1'b0;
  logic        wordLen32, bigEndian, highSpeed, irqActiveHigh;
  logic        statusEn, irqWithStatus, wakeReq, irqPin;

  int nChecks = 0;
  int nFails = 0;
  int cycles = 0;
  bit done = 0;

  always #10 clk = ~clk;

  spi_fn0_regbank u_spi_fn0_regbank (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .evtSet(evtSet),
    .evtClear(evtClear), .statusIn(statusIn), .statusActive(statusActive),
    .wordLen32(wordLen32), .bigEndian(bigEndian), .highSpeed(highSpeed),
    .irqActiveHigh(irqActiveHigh), .statusEn(statusEn),
    .irqWithStatus(irqWithStatus), .wakeReq(wakeReq), .irqPin(irqPin)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdChk(input string req, input logic [5:0] a, input logic [7:0] exp);
    regAddr = a;
    #1;
    chk(req, {24'b0, regRdData}, {24'b0, exp});
  endtask

  task automatic pulse(input logic [15:0] s, input logic [15:0] c);
    @(negedge clk);
    evtSet = s; evtClear = c;
    @(negedge clk);
    evtSet = '0; evtClear = '0;
  endtask

  task automatic t_reset();
    rdChk("R1 cfg", 6'h00, 8'h30);
    rdChk("R1 rpt", 6'h02, 8'h00);
    rdChk("R1 irqlo", 6'h04, 8'h00);
    rdChk("R1 irqhi", 6'h05, 8'h00);
    rdChk("R1 ienlo", 6'h06, 8'hE7);
    rdChk("R1 ienhi", 6'h07, 8'hE0);
    rdChk("R1 stw0", 6'h08, 8'h00);
    rdChk("R1 stw3", 6'h0B, 8'h00);
    chk("R1 wake", {31'b0, wakeReq}, 0);
    chk("R1 pin", {31'b0, irqPin}, 0);
  endtask

  task automatic t_busCfg();
    wr(6'h00, 8'h7F);
    rdChk("R2 masked", 6'h00, 8'h33);
    chk("R2 outs", {28'b0, wordLen32, bigEndian, highSpeed, irqActiveHigh}, 4'b1111);
    chk("R3 no wake", {31'b0, wakeReq}, 0);
    wr(6'h00, 8'h00);
    chk("R2 cleared", {28'b0, wordLen32, bigEndian, highSpeed, irqActiveHigh}, 4'b0000);
    wr(6'h00, 8'h30);
    chk("R2 restore", {28'b0, wordLen32, bigEndian, highSpeed, irqActiveHigh}, 4'b0011);
  endtask

  task automatic t_wake();
    wr(6'h00, 8'hB0);
    chk("R3 pulse", {31'b0, wakeReq}, 1);
    rdChk("R3 readback", 6'h00, 8'hB0);
    @(negedge clk);
    chk("R3 one cycle", {31'b0, wakeReq}, 0);
    wr(6'h00, 8'h30);
    chk("R3 clear no pulse", {31'b0, wakeReq}, 0);
  endtask

  task automatic t_rpt();
    wr(6'h02, 8'hFF);
    rdChk("R4 rpt", 6'h02, 8'h03);
    chk("R4 outs", {30'b0, statusEn, irqWithStatus}, 2'b11);
    wr(6'h03, 8'hFF);
    rdChk("R4 rsvd3", 6'h03, 8'h00);
    wr(6'h01, 8'hFF);
    rdChk("R4 rsvd1", 6'h01, 8'h00);
    rdChk("R4 cfg kept", 6'h00, 8'h30);
    wr(6'h02, 8'h00);
    chk("R4 off", {30'b0, statusEn, irqWithStatus}, 2'b00);
  endtask

  task automatic t_events();
    pulse(16'hFFFF, 16'h0000);
    rdChk("R5 lo", 6'h04, 8'hE7);
    rdChk("R5 hi", 6'h05, 8'hE0);
    wr(6'h04, 8'hFE);
    rdChk("R6 ro lo", 6'h04, 8'hE7);
    wr(6'h05, 8'hFF);
    rdChk("R6 ro hi", 6'h05, 8'hE0);
    wr(6'h04, 8'h01);
    rdChk("R6 w1c", 6'h04, 8'hE6);
  endtask

  task automatic t_setWins();
    @(negedge clk);
    regAddr = 6'h04; regWrData = 8'h01; regWrEn = 1'b1; evtSet = 16'h0001;
    @(negedge clk);
    regWrEn = 1'b0; evtSet = '0;
    rdChk("R7 w1c vs set", 6'h04, 8'hE7);
    pulse(16'h0020, 16'h0020);
    rdChk("R7 clr vs set", 6'h04, 8'hE7);
    pulse(16'h0000, 16'h00E6);
    rdChk("R8 clr lo", 6'h04, 8'h01);
    pulse(16'h0000, 16'hFFFF);
    rdChk("R8 clr all", 6'h04, 8'h00);
    rdChk("R8 clr hi", 6'h05, 8'h00);
  endtask

  task automatic t_pin();
    wr(6'h06, 8'h00);
    wr(6'h07, 8'h00);
    rdChk("R9 ienlo", 6'h06, 8'h00);
    rdChk("R9 ienhi", 6'h07, 8'h00);
    pulse(16'h0002, 16'h0000);
    chk("R10 masked", {31'b0, irqPin}, 0);
    wr(6'h06, 8'h02);
    chk("R10 high", {31'b0, irqPin}, 1);
    wr(6'h00, 8'h10);
    chk("R10 low pol", {31'b0, irqPin}, 0);
    pulse(16'h0000, 16'h0002);
    chk("R10 idle low pol", {31'b0, irqPin}, 1);
    wr(6'h00, 8'h30);
    wr(6'h07, 8'hA5);
    rdChk("R9 ienhi wr", 6'h07, 8'hA5);
    rdChk("R9 ienlo kept", 6'h06, 8'h02);
  endtask

  task automatic t_suppress();
    pulse(16'h0002, 16'h0000);
    @(negedge clk);
    statusActive = 1'b1;
    #1;
    chk("R11 quiet", {31'b0, irqPin}, 0);
    wr(6'h02, 8'h02);
    chk("R11 with status", {31'b0, irqPin}, 1);
    statusActive = 1'b0;
    wr(6'h02, 8'h00);
    chk("R11 after", {31'b0, irqPin}, 1);
    pulse(16'h0000, 16'hFFFF);
  endtask

  task automatic t_status();
    @(negedge clk);
    statusIn = 32'hA1B2C3D4;
    @(negedge clk);
    rdChk("R12 b0", 6'h08, 8'hD4);
    rdChk("R12 b1", 6'h09, 8'hC3);
    rdChk("R12 b2", 6'h0A, 8'hB2);
    rdChk("R12 b3", 6'h0B, 8'hA1);
    wr(6'h08, 8'h00);
    rdChk("R12 ro", 6'h08, 8'hD4);
    rdChk("R12 unmapped", 6'h20, 8'h00);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: got %0d cycles expected completion", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_busCfg();
    t_wake();
    t_rpt();
    t_events();
    t_setWins();
    t_pin();
    t_suppress();
    t_status();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule